// File: doc/BRIEF.md
# Comparand and Sliding-Mask Register Unit

This unit holds the search key and the two bit masks used by a content-addressable lookup engine. A 64-bit comparand supplies the search word. Mask one has two stored copies, a foreground and a background. A select input picks which copy drives masking. Mask two is a sliding mask. It can be widened or narrowed one bit at a time by copying its edge bit inward.

A partition code splits each word into a searchable field and an associated-data field on 16-bit boundaries. Every rotate of the comparand and every slide of mask two stays inside the searchable field. A load into any register can be gated bit by bit by either mask. A mask bit of 0 lets the new bit in. A mask bit of 1 keeps the old bit.

Top module: `cmp_mask_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, and on the first cycle after it, the comparand, both copies of mask one and mask two are all zeros.
- R2: A shift with target comparand (sh_tgt=0) and sh_left=0 rotates the searchable field one place toward bit 0. The field's lowest bit re-enters at its highest bit.
- R3: A comparand shift with sh_left=1 rotates the searchable field one place toward the MSB. The field's highest bit re-enters at its lowest bit.
- R4: A shift with target mask two (sh_tgt=1) and sh_left=0 moves the field one place toward bit 0. The field's top bit keeps its value and is also copied into the position below it. Nothing wraps around.
- R5: A mask-two shift with sh_left=1 moves the field one place toward the MSB. The field's bottom bit keeps its value and is also copied into the position above it.
- R6: A shift changes no bit outside the searchable field and leaves the register that was not targeted unchanged. With no command, all registers hold.
- R7: Writes use wr_dest 0 for the comparand, 1 for the mask-one foreground, 2 for the mask-one background and 3 for mask two. wr_msel 1 masks with the active mask one, 2 masks with mask two, and 0 or 3 means unmasked. In the destination, bits whose mask bit is 0 take wr_data and bits whose mask bit is 1 keep their value.
- R8: mask1_active shows the foreground copy when mask1_use_bg is 0 and the background copy when it is 1. Masked writes use the copy shown there.
- R9: Only one command takes effect per clock. When wr_en and sh_en are both high, the write is performed and the shift is dropped.
- R10: The searchable field is set as follows. part_code[1:0] gives the number n of 16-bit data segments. When part_code[2]=0, the data sits in the low bits and the field is bits 63 down to 16n. When part_code[2]=1, the data sits in the high bits and the field is bits 63-16n down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_code | input | 3 | Field partition code |
| mask1_use_bg | input | 1 | Selects the background copy of mask one |
| wr_en | input | 1 | Write request |
| wr_dest | input | 2 | Write destination register |
| wr_msel | input | 2 | Write mask select |
| wr_data | input | 64 | Write data |
| sh_en | input | 1 | Shift request |
| sh_tgt | input | 1 | Shift target: 0 comparand, 1 mask two |
| sh_left | input | 1 | Shift direction: 1 toward MSB, 0 toward bit 0 |
| comparand | output | 64 | Comparand register |
| mask1_fg | output | 64 | Mask one, foreground copy |
| mask1_bg | output | 64 | Mask one, background copy |
| mask1_active | output | 64 | Currently selected copy of mask one |
| mask2 | output | 64 | Sliding mask register |

## Verification
All eight partition codes are swept. Under each code, single bits are placed on the lowest and highest field positions. These separate a true wrap or replicate from a plain shift, and show whether the limits are correct. Dense pseudo-random words and a full-length rotation expose lost or duplicated bits and any leakage across the field boundary. Masked loads are then run through every destination and mask select, with distinct foreground and background contents, so a wrong active copy or an inverted mask sense shows up. Simultaneous write and shift requests confirm that the write wins.

// File: rtl/cmp_mask_pkg.sv
`timescale 1ns/1ps
package cmp_mask_pkg;

    localparam int DEF_WORD_W = 64;
    localparam int DEF_SEG_W  = 16;

    typedef enum logic [1:0] {
        DST_CMP  = 2'd0,
        DST_M1FG = 2'd1,
        DST_M1BG = 2'd2,
        DST_M2   = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        MSK_NONE  = 2'd0,
        MSK_M1    = 2'd1,
        MSK_M2    = 2'd2,
        MSK_NONE3 = 2'd3
    } msel_e;

endpackage

// File: rtl/cam_field_decode.sv
`timescale 1ns/1ps
module cam_field_decode #(
    parameter int W      = 64,
    parameter int SEG_W  = 16,
    localparam int NSEG  = W / SEG_W,
    localparam int CNT_W = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int PART_W = CNT_W + 1,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [PART_W-1:0] part_code,
    output logic [IDX_W-1:0]  field_lo,
    output logic [IDX_W-1:0]  field_hi
);

    logic [CNT_W-1:0] seg_cnt;
    int               data_bits;

    always_comb begin
        seg_cnt = part_code[CNT_W-1:0];
        // keep at least one searchable segment
        if (int'(seg_cnt) > NSEG - 1) begin
            seg_cnt = CNT_W'(NSEG - 1);
        end
        data_bits = int'(seg_cnt) * SEG_W;
        if (part_code[PART_W-1]) begin
            field_lo = '0;
            field_hi = IDX_W'(W - 1 - data_bits);
        end else begin
            field_lo = IDX_W'(data_bits);
            field_hi = IDX_W'(W - 1);
        end
    end

endmodule

// File: rtl/field_shifter.sv
`timescale 1ns/1ps
module field_shifter #(
    parameter int W     = 64,
    parameter bit WRAP  = 1'b1,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [IDX_W-1:0] field_lo,
    input  logic [IDX_W-1:0] field_hi,
    input  logic             shift_left,
    output logic [W-1:0]     dout
);

    // WRAP=1: rotate inside the field; WRAP=0: edge bit is held and copied inward
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int UP = (i == W - 1) ? i : i + 1;
        localparam int DN = (i == 0) ? i : i - 1;
        localparam logic [IDX_W-1:0] POS = IDX_W'(i);

        logic in_field;
        logic from_right;
        logic from_left;

        assign in_field   = (POS >= field_lo) && (POS <= field_hi);
        assign from_right = (POS == field_hi) ? (WRAP ? din[field_lo] : din[i]) : din[UP];
        assign from_left  = (POS == field_lo) ? (WRAP ? din[field_hi] : din[i]) : din[DN];
        assign dout[i]    = !in_field  ? din[i] :
                            shift_left ? from_left : from_right;
    end

endmodule

// File: rtl/cmp_mask_unit.sv
`timescale 1ns/1ps
module cmp_mask_unit
    import cmp_mask_pkg::*;
#(
    parameter int W      = DEF_WORD_W,
    parameter int SEG_W  = DEF_SEG_W,
    localparam int NSEG  = W / SEG_W,
    localparam int PART_W = ((NSEG > 1) ? $clog2(NSEG) : 1) + 1,
    localparam int IDX_W = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PART_W-1:0] part_code,
    input  logic              mask1_use_bg,
    input  logic              wr_en,
    input  logic [1:0]        wr_dest,
    input  logic [1:0]        wr_msel,
    input  logic [W-1:0]      wr_data,
    input  logic              sh_en,
    input  logic              sh_tgt,
    input  logic              sh_left,
    output logic [W-1:0]      comparand,
    output logic [W-1:0]      mask1_fg,
    output logic [W-1:0]      mask1_bg,
    output logic [W-1:0]      mask1_active,
    output logic [W-1:0]      mask2
);

    typedef struct packed {
        logic [W-1:0] cmp;
        logic [W-1:0] m1fg;
        logic [W-1:0] m1bg;
        logic [W-1:0] m2;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0] field_lo;
    logic [IDX_W-1:0] field_hi;
    logic [W-1:0]     cmp_rot;
    logic [W-1:0]     m2_slid;
    logic [W-1:0]     m1_sel;
    logic [W-1:0]     wmask;

    cam_field_decode #(.W(W), .SEG_W(SEG_W)) u_decode (
        .part_code (part_code),
        .field_lo  (field_lo),
        .field_hi  (field_hi)
    );

    field_shifter #(.W(W), .WRAP(1'b1)) u_cmp_rot (
        .din        (q.cmp),
        .field_lo   (field_lo),
        .field_hi   (field_hi),
        .shift_left (sh_left),
        .dout       (cmp_rot)
    );

    field_shifter #(.W(W), .WRAP(1'b0)) u_m2_slide (
        .din        (q.m2),
        .field_lo   (field_lo),
        .field_hi   (field_hi),
        .shift_left (sh_left),
        .dout       (m2_slid)
    );

    always_comb begin
        d      = q;
        m1_sel = mask1_use_bg ? q.m1bg : q.m1fg;

        case (msel_e'(wr_msel))
            MSK_M1:  wmask = m1_sel;
            MSK_M2:  wmask = q.m2;
            default: wmask = '0;
        endcase

        if (wr_en) begin
            case (dest_e'(wr_dest))
                DST_CMP:  d.cmp  = (q.cmp  & wmask) | (wr_data & ~wmask);
                DST_M1FG: d.m1fg = (q.m1fg & wmask) | (wr_data & ~wmask);
                DST_M1BG: d.m1bg = (q.m1bg & wmask) | (wr_data & ~wmask);
                default:  d.m2   = (q.m2   & wmask) | (wr_data & ~wmask);
            endcase
        end else if (sh_en) begin
            if (sh_tgt) begin
                d.m2 = m2_slid;
            end else begin
                d.cmp = cmp_rot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign comparand    = q.cmp;
    assign mask1_fg     = q.m1fg;
    assign mask1_bg     = q.m1bg;
    assign mask1_active = m1_sel;
    assign mask2        = q.m2;

endmodule

// File: rtl/cmp_mask_chk.sv
`timescale 1ns/1ps
module cmp_mask_chk #(
    parameter int W = 64,
    localparam int IDX_W = $clog2(W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_dest,
    input logic [1:0]       wr_msel,
    input logic [W-1:0]     wr_data,
    input logic             sh_en,
    input logic             sh_tgt,
    input logic             sh_left,
    input logic [W-1:0]     comparand,
    input logic [W-1:0]     mask1_fg,
    input logic [W-1:0]     mask1_bg,
    input logic [W-1:0]     mask2,
    input logic [IDX_W-1:0] field_lo,
    input logic [IDX_W-1:0] field_hi
);

    logic [W-1:0] fmask;
    assign fmask = ({W{1'b1}} << field_lo) & ({W{1'b1}} >> (W - 1 - int'(field_hi)));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (comparand == '0 && mask1_fg == '0 && mask1_bg == '0 && mask2 == '0));

    p_rotate_keeps_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en && !wr_en && !sh_tgt) |=> $countones(comparand) == $countones($past(comparand)));

    p_slide_right_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en && !wr_en && sh_tgt && !sh_left) |=>
        (mask2[$past(field_hi)] == $past(mask2[field_hi]) &&
         mask2[$past(field_hi) - 1'b1] == $past(mask2[field_hi])));

    p_slide_left_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en && !wr_en && sh_tgt && sh_left) |=>
        (mask2[$past(field_lo)] == $past(mask2[field_lo]) &&
         mask2[$past(field_lo) + 1'b1] == $past(mask2[field_lo])));

    p_outside_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en && !wr_en) |=>
        (((comparand ^ $past(comparand)) & ~$past(fmask)) == '0 &&
         ((mask2 ^ $past(mask2)) & ~$past(fmask)) == '0));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_en && !wr_en) |=>
        ($stable(comparand) && $stable(mask1_fg) && $stable(mask1_bg) && $stable(mask2)));

    p_masked_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dest == 2'd0 && wr_msel == 2'd2) |=>
        (comparand & $past(mask2)) == $past(comparand & mask2));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sh_en && wr_dest == 2'd0 && wr_msel == 2'd0) |=>
        comparand == $past(wr_data));

endmodule

bind cmp_mask_unit cmp_mask_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_dest   (wr_dest),
    .wr_msel   (wr_msel),
    .wr_data   (wr_data),
    .sh_en     (sh_en),
    .sh_tgt    (sh_tgt),
    .sh_left   (sh_left),
    .comparand (comparand),
    .mask1_fg  (mask1_fg),
    .mask1_bg  (mask1_bg),
    .mask2     (mask2),
    .field_lo  (field_lo),
    .field_hi  (field_hi)
);

// File: tb/cmp_mask_unit_bench.sv
`timescale 1ns/1ps
module cmp_mask_unit_bench;

    localparam int W = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  part_code;
    logic        mask1_use_bg;
    logic        wr_en;
    logic [1:0]  wr_dest;
    logic [1:0]  wr_msel;
    logic [W-1:0] wr_data;
    logic        sh_en;
    logic        sh_tgt;
    logic        sh_left;
    logic [W-1:0] comparand, mask1_fg, mask1_bg, mask1_active, mask2;

    always #2.5 clk = ~clk;

    cmp_mask_unit u_cmp_mask_unit (
        .clk(clk), .rst_n(rst_n), .part_code(part_code), .mask1_use_bg(mask1_use_bg),
        .wr_en(wr_en), .wr_dest(wr_dest), .wr_msel(wr_msel), .wr_data(wr_data),
        .sh_en(sh_en), .sh_tgt(sh_tgt), .sh_left(sh_left),
        .comparand(comparand), .mask1_fg(mask1_fg), .mask1_bg(mask1_bg),
        .mask1_active(mask1_active), .mask2(mask2)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_cmp, m_fg, m_bg, m_m2;
    logic [W-1:0] seed = 64'h9E37_79B9_7F4A_7C15;
    int f_lo, f_len;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " comparand"}, comparand, m_cmp);
        chk({tag, " mask1_fg"}, mask1_fg, m_fg);
        chk({tag, " mask1_bg"}, mask1_bg, m_bg);
        chk({tag, " mask2"}, mask2, m_m2);
        chk({tag, " mask1_active"}, mask1_active, mask1_use_bg ? m_bg : m_fg);
    endtask

    // R10: field from partition code
    task automatic set_field(input logic [2:0] code);
        int n;
        n = int'(code[1:0]);
        f_len = W - 16 * n;
        f_lo  = code[2] ? 0 : 16 * n;
    endtask

    function automatic logic [W-1:0] fshift(input logic [W-1:0] v, input int lo, input int len,
                                             input bit left, input bit wrap);
        logic [W-1:0] m, f, nf, top, bot;
        m   = (len >= W) ? '1 : ((64'd1 << len) - 64'd1);
        f   = (v >> lo) & m;
        bot = {63'd0, f[0]};
        top = {63'd0, f[len-1]};
        if (!left) nf = (f >> 1) | ((wrap ? bot : top) << (len - 1));
        else       nf = ((f << 1) & m) | (wrap ? top : bot);
        return (v & ~(m << lo)) | (nf << lo);
    endfunction

    function automatic logic [W-1:0] next_rand(input logic [W-1:0] s);
        logic [W-1:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic do_op(input logic we, input logic [1:0] dest, input logic [1:0] msel,
                         input logic [W-1:0] data, input logic se, input logic tgt,
                         input logic left, input string tag);
        logic [W-1:0] mk;
        wr_en = we; wr_dest = dest; wr_msel = msel; wr_data = data;
        sh_en = se; sh_tgt = tgt; sh_left = left;
        @(negedge clk);
        wr_en = 1'b0; sh_en = 1'b0;
        if (we) begin
            mk = (msel == 2'd1) ? (mask1_use_bg ? m_bg : m_fg) :
                 (msel == 2'd2) ? m_m2 : '0;
            case (dest)
                2'd0: m_cmp = (m_cmp & mk) | (data & ~mk);
                2'd1: m_fg  = (m_fg  & mk) | (data & ~mk);
                2'd2: m_bg  = (m_bg  & mk) | (data & ~mk);
                default: m_m2 = (m_m2 & mk) | (data & ~mk);
            endcase
        end else if (se) begin
            if (tgt) m_m2  = fshift(m_m2,  f_lo, f_len, left, 1'b0);
            else     m_cmp = fshift(m_cmp, f_lo, f_len, left, 1'b1);
        end
        check_all(tag);
    endtask

    function automatic logic [W-1:0] pick(input int k, input logic [W-1:0] r);
        case (k)
            0: return 64'd1 << f_lo;
            1: return 64'd1 << (f_lo + f_len - 1);
            2: return 64'd3 << f_lo;
            3: return 64'hF0F0_0FF0_A5A5_C33C;
            default: return r;
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; part_code = 3'd0; mask1_use_bg = 1'b0;
        wr_en = 1'b0; wr_dest = 2'd0; wr_msel = 2'd0; wr_data = '0;
        sh_en = 1'b0; sh_tgt = 1'b0; sh_left = 1'b0;
        m_cmp = '0; m_fg = '0; m_bg = '0; m_m2 = '0;
        set_field(3'd0);
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2 R3 R4 R5 R6 R10: every partition code, edge bits and dense words
        for (int code = 0; code < 8; code++) begin
            part_code = 3'(code);
            set_field(3'(code));
            for (int k = 0; k < 7; k++) begin
                logic [W-1:0] a, b;
                seed = next_rand(seed); a = pick(k, seed);
                seed = next_rand(seed); b = pick(k, seed);
                do_op(1'b1, 2'd0, 2'd0, a, 1'b0, 1'b0, 1'b0, "R7 load cmp");
                do_op(1'b1, 2'd3, 2'd0, b, 1'b0, 1'b0, 1'b0, "R7 load mask2");
                do_op(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b0, 1'b0, "R2 R6 R10 rotate right");
                do_op(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b0, 1'b1, "R3 R6 R10 rotate left");
                do_op(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b0, 1'b1, "R3 R6 R10 rotate left");
                do_op(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b1, 1'b0, "R4 R6 R10 slide right");
                do_op(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b1, 1'b0, "R4 R6 R10 slide right");
                do_op(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b1, 1'b1, "R5 R6 R10 slide left");
                do_op(1'b0, 2'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0, "R6 idle hold");
            end
            // R2: a full-length rotation restores the word
            begin
                logic [W-1:0] orig;
                seed = next_rand(seed); orig = seed;
                do_op(1'b1, 2'd0, 2'd0, orig, 1'b0, 1'b0, 1'b0, "R7 load cmp");
                for (int s = 0; s < f_len; s++)
                    do_op(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b0, 1'b0, "R2 R10 rotate sweep");
                chk("R2 full rotation", comparand, orig);
            end
        end

        // R7 R8: masked loads through every destination and select
        part_code = 3'd0; set_field(3'd0);
        do_op(1'b1, 2'd1, 2'd0, 64'h0000_FFFF_0000_FFFF, 1'b0, 1'b0, 1'b0, "R8 load fg");
        do_op(1'b1, 2'd2, 2'd0, 64'hFF00_FF00_FF00_FF00, 1'b0, 1'b0, 1'b0, "R8 load bg");
        do_op(1'b1, 2'd3, 2'd0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 1'b0, 1'b0, "R7 load mask2");
        chk("R8 foreground active", mask1_active, 64'h0000_FFFF_0000_FFFF);
        do_op(1'b1, 2'd0, 2'd0, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b0, "R7 unmasked");
        do_op(1'b1, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, "R7 R8 masked by fg");
        mask1_use_bg = 1'b1;
        #1;
        chk("R8 background active", mask1_active, 64'hFF00_FF00_FF00_FF00);
        do_op(1'b1, 2'd0, 2'd1, 64'h0000_0000_0000_0000, 1'b0, 1'b0, 1'b0, "R7 R8 masked by bg");
        do_op(1'b1, 2'd0, 2'd2, 64'hAAAA_5555_AAAA_5555, 1'b0, 1'b0, 1'b0, "R7 masked by mask2");
        do_op(1'b1, 2'd0, 2'd3, 64'hC0DE_C0DE_C0DE_C0DE, 1'b0, 1'b0, 1'b0, "R7 select 3 unmasked");
        do_op(1'b1, 2'd1, 2'd2, 64'h0, 1'b0, 1'b0, 1'b0, "R7 fg masked by mask2");
        do_op(1'b1, 2'd3, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, "R7 mask2 masked by bg");
        do_op(1'b1, 2'd2, 2'd1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b0, "R7 bg masked by itself");
        mask1_use_bg = 1'b0;
        #1;
        chk("R8 back to foreground", mask1_active, m_fg);

        // R9: write beats shift
        part_code = 3'd5; set_field(3'd5);
        do_op(1'b1, 2'd0, 2'd0, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b0, "R9 write over rotate");
        do_op(1'b1, 2'd0, 2'd0, 64'h7777_0000_1111_2222, 1'b1, 1'b1, 1'b1, "R9 write over slide");
        do_op(1'b1, 2'd3, 2'd0, 64'h0000_0000_0000_8001, 1'b1, 1'b0, 1'b1, "R9 mask2 write over rotate");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule